// File: doc/BRIEF.md
# Configurable Single-Port RAM

This block is a parameterised single-port memory for use inside a larger design. One address bus serves reads and writes. A write updates only the byte lanes selected by a per-lane mask. A read returns the stored word, or the merged new word when a write hits the same cycle. The read-data port always comes from a register. A second, optional output register adds one cycle of latency and can run on a separate output clock.

Address, write data, lane mask, write strobe and read strobe all act on the rising edge of the input clock. An active-low hold input freezes the latched address, so the block keeps working on the previous location. The input and output register stages each have their own clock enable. An asynchronous active-low clear empties the address and read registers but leaves the stored words alone. Every stored word is zero after start-up.

Top module: `spram_wrap`

## Requirements
- R1: After start-up, a read of any address returns zero.
- R2: A write with every lane enabled stores the whole word. The read-data port shows a read one input-clock cycle after it is presented when the output register is off (OUT_REG=0), and two cycles after when it is on (OUT_REG=1).
- R3: Bit i of `byte_en` covers data bits [i*BYTE_W +: BYTE_W]. A write changes only the lanes whose bit is 1. Lanes with a 0 keep their stored value.
- R4: When the read strobe and the write strobe are both high in the same cycle, the read result holds the new data in the enabled lanes and the previously stored data in the masked lanes.
- R5: While `addr_hold_n` is 0 on an enabled input edge, the address presented on `addr` is ignored. Both read and write use the previously latched address, and that address stays latched.
- R6: On an enabled input edge with `rd_en` at 0, the read register keeps its previous value.
- R7: On an input edge with `in_ce` at 0, nothing happens. No word is written, the latched address is kept and the read register keeps its value.
- R8: On an output-register edge with `out_ce` at 0, `rdata` keeps its previous value.
- R9: While `clr_n` is 0, the latched address and the read registers are zero without waiting for a clock edge (the output register only when CLR_Q=1). Stored words keep their contents.
- R10: With DUAL_CLK=1, the output register changes only on rising edges of `out_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Clock for the address, write and read stages |
| out_clk | input | 1 | Clock for the output register when DUAL_CLK=1 |
| clr_n | input | 1 | Asynchronous active-low clear of the registered stages |
| in_ce | input | 1 | Clock enable for the input stages (USE_IN_CE=1) |
| out_ce | input | 1 | Clock enable for the output register (USE_OUT_CE=1) |
| addr_hold_n | input | 1 | Active-low hold: when 0, the latched address is kept |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| byte_en | input | DATA_W/BYTE_W | Lane mask for writes (USE_BE=1) |
| rd_en | input | 1 | Read strobe (USE_RD_EN=1) |
| rdata | output | DATA_W | Registered read data |

## Verification
The assertions assume that every control input is driven to 0 or 1 at each clock edge once `clr_n` is high. They also assume that `clr_n` changes away from active clock edges. The bench drives all inputs on the falling edge of the input clock and asserts and releases the clear there too, so neither assumption is broken. The output clock of the dual-clock instance is pulsed only between input edges. Before the first pulse it is held low during the clear, so that register always starts from a defined value.

// File: rtl/spram_pkg.sv
// Package: shared helpers for the single-port RAM wrapper.
// Assumes: nothing beyond integer parameters passed at elaboration.
package spram_pkg;

    // True when the lane width is one of the supported sizes.
    function automatic bit lane_width_ok(input int unsigned w);
        return (w == 8) || (w == 9) || (w == 10);
    endfunction

    // Number of lanes in a word of the given width.
    function automatic int unsigned lane_count(input int unsigned dw, input int unsigned bw);
        return dw / bw;
    endfunction

endpackage

// File: rtl/spram_addr_stage.sv
// Module: address register with hold.
// Does: passes the incoming address through when hold_n is 1, otherwise the
//       latched address. Latches the address in use on every enabled edge.
// Assumes: ce already reflects the clock-enable option chosen at the top.
module spram_addr_stage #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              ce,
    input  logic              hold_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_use,
    output logic [ADDR_W-1:0] addr_q
);

    // Choose between the new address and the latched one.
    always_comb begin
        addr_use = hold_n ? addr_in : addr_q;
    end

    // Latch the address in use; cleared asynchronously.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            addr_q <= '0;
        end else if (ce) begin
            addr_q <= addr_use;
        end
    end

    // R5: a held edge must leave the latched address unchanged.
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (ce && !hold_n) |=> (addr_q == $past(addr_q)))
        else $error("address moved while held");

    // R7: a disabled edge must leave the latched address unchanged.
    assert_addr_noce_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (!ce) |=> (addr_q == $past(addr_q)))
        else $error("address moved without clock enable");

endmodule

// File: rtl/spram_array.sv
// Module: storage array and read register.
// Does: writes the masked lanes and registers the read word, passing new
//       data through when a read and a write share the edge.
// Assumes: the word count is a power of two; the array starts at zero.
module spram_array #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned BYTE_W   = 8,
    parameter bit          CLEAR_RD = 1'b1
) (
    input  logic                     clk,
    input  logic                     clr_n,
    input  logic                     ce,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     we,
    input  logic [DATA_W/BYTE_W-1:0] be,
    input  logic                     re,
    output logic [DATA_W-1:0]        rd_q
);

    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned LANES = spram_pkg::lane_count(DATA_W, BYTE_W);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] rd_next;

    // Give every word a zero start value.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = '0;
        end
    end

    // Build the word a write would leave behind.
    always_comb begin
        old_word = mem[addr];
        for (int l = 0; l < LANES; l++) begin
            merged[l*BYTE_W +: BYTE_W] = be[l] ? wdata[l*BYTE_W +: BYTE_W]
                                               : old_word[l*BYTE_W +: BYTE_W];
        end
        rd_next = we ? merged : old_word;
    end

    // Store the merged word on an enabled write edge.
    always_ff @(posedge clk) begin
        if (clr_n && ce && we) begin
            mem[addr] <= merged;
        end
    end

    generate
        if (CLEAR_RD) begin : g_rd_clr
            // Read register with asynchronous clear.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    rd_q <= '0;
                end else if (ce && re) begin
                    rd_q <= rd_next;
                end
            end
        end else begin : g_rd_keep
            // Read register untouched by the clear.
            always_ff @(posedge clk) begin
                if (ce && re) begin
                    rd_q <= rd_next;
                end
            end
        end
    endgenerate

    // R4: a read-during-write with every lane enabled returns the write data.
    assert_rdw_new_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (ce && re && we && (&be)) |=> (rd_q == $past(wdata)))
        else $error("read-during-write did not return new data");

    // R6: a disabled read keeps the read register.
    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!clr_n)
        (ce && !re) |=> $stable(rd_q))
        else $error("read register moved without read strobe");

    // R7: a disabled edge keeps the read register.
    assert_rd_noce_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (!ce) |=> $stable(rd_q))
        else $error("read register moved without clock enable");

endmodule

// File: rtl/spram_out_stage.sv
// Module: optional output register.
// Does: either passes the read register straight through or re-registers it
//       on the selected output clock, with an optional asynchronous clear.
// Assumes: clk is already the chosen clock (input or separate output clock).
module spram_out_stage #(
    parameter int unsigned DATA_W  = 16,
    parameter bit          OUT_REG = 1'b1,
    parameter bit          CLR_Q   = 1'b1
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              ce,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    generate
        if (!OUT_REG) begin : g_thru
            // No extra stage: the read register drives the port.
            always_comb begin
                q = d;
            end
        end else if (CLR_Q) begin : g_reg_clr
            // Output register with asynchronous clear.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    q <= '0;
                end else if (ce) begin
                    q <= d;
                end
            end
        end else begin : g_reg_keep
            // Output register that ignores the clear.
            always_ff @(posedge clk) begin
                if (ce) begin
                    q <= d;
                end
            end
        end
    endgenerate

    generate
        if (OUT_REG) begin : g_chk
            // R8: a disabled output edge keeps the port value.
            assert_out_hold_R8: assert property (@(posedge clk) disable iff (!clr_n)
                (!ce) |=> $stable(q))
                else $error("output register moved without clock enable");
            // R2: an enabled output edge copies the read register.
            assert_out_copy_R2: assert property (@(posedge clk) disable iff (!clr_n)
                ce |=> (q == $past(d)))
                else $error("output register missed the read word");
        end
    endgenerate

endmodule

// File: rtl/spram_wrap.sv
// Module: top of the configurable single-port RAM.
// Does: applies the option parameters to the enables, then chains the
//       address stage, the array with its read register and the output stage.
// Assumes: DATA_W is a multiple of BYTE_W, and BYTE_W is 8, 9 or 10; clr_n
//          changes away from the active clock edges.
module spram_wrap #(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned BYTE_W     = 8,
    parameter bit          OUT_REG    = 1'b1,
    parameter bit          DUAL_CLK   = 1'b0,
    parameter bit          USE_IN_CE  = 1'b1,
    parameter bit          USE_OUT_CE = 1'b1,
    parameter bit          USE_BE     = 1'b1,
    parameter bit          USE_RD_EN  = 1'b1,
    parameter bit          CLR_Q      = 1'b1
) (
    input  logic                     in_clk,
    input  logic                     out_clk,
    input  logic                     clr_n,
    input  logic                     in_ce,
    input  logic                     out_ce,
    input  logic                     addr_hold_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     wr_en,
    input  logic [DATA_W/BYTE_W-1:0] byte_en,
    input  logic                     rd_en,
    output logic [DATA_W-1:0]        rdata
);

    localparam int unsigned LANES    = spram_pkg::lane_count(DATA_W, BYTE_W);
    localparam bit          CLEAR_RD = OUT_REG || CLR_Q;

    // Reject configurations that cannot be split into lanes.
    generate
        if ((DATA_W % BYTE_W) != 0) begin : g_bad_ratio
            $error("DATA_W must be a multiple of BYTE_W");
        end
        if (!spram_pkg::lane_width_ok(BYTE_W)) begin : g_bad_lane
            $error("BYTE_W must be 8, 9 or 10");
        end
    endgenerate

    logic              ice;
    logic              oce;
    logic              oclk;
    logic              re_use;
    logic [LANES-1:0]  be_use;
    logic [ADDR_W-1:0] addr_use;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rd_q;

    // Resolve the option parameters into the enables the stages use.
    always_comb begin
        ice    = USE_IN_CE ? in_ce : 1'b1;
        oce    = USE_OUT_CE ? out_ce : (DUAL_CLK ? 1'b1 : ice);
        re_use = USE_RD_EN ? rd_en : 1'b1;
        be_use = USE_BE ? byte_en : '1;
    end

    // Pick the clock for the output register.
    assign oclk = DUAL_CLK ? out_clk : in_clk;

    spram_addr_stage #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk      (in_clk),
        .clr_n    (clr_n),
        .ce       (ice),
        .hold_n   (addr_hold_n),
        .addr_in  (addr),
        .addr_use (addr_use),
        .addr_q   (addr_q)
    );

    spram_array #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BYTE_W   (BYTE_W),
        .CLEAR_RD (CLEAR_RD)
    ) u_array (
        .clk   (in_clk),
        .clr_n (clr_n),
        .ce    (ice),
        .addr  (addr_use),
        .wdata (wdata),
        .we    (wr_en),
        .be    (be_use),
        .re    (re_use),
        .rd_q  (rd_q)
    );

    spram_out_stage #(
        .DATA_W  (DATA_W),
        .OUT_REG (OUT_REG),
        .CLR_Q   (CLR_Q)
    ) u_out (
        .clk   (oclk),
        .clr_n (clr_n),
        .ce    (oce),
        .d     (rd_q),
        .q     (rdata)
    );

    // R9: while the clear is low, the latched address reads as zero.
    assert_clr_addr_R9: assert property (@(posedge in_clk)
        (!clr_n) |-> (addr_q == '0))
        else $error("latched address not cleared");

endmodule

// File: tb/spram_wrap_tb.sv
// Bench: three configurations driven by the same stimulus, compared with a
// model built from the requirements.
module spram_wrap_tb;

    localparam int AW = 4;
    localparam int DW = 16;
    localparam int BW = 8;
    localparam int NB = DW / BW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic oclk = 1'b0;

    logic          clr_n = 1'b0;
    logic          in_ce = 1'b1;
    logic          out_ce = 1'b1;
    logic          hold_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          we = 1'b0;
    logic [NB-1:0] be = '1;
    logic          re = 1'b0;
    logic [DW-1:0] rd_main, rd_flow, rd_dual;

    spram_wrap #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW), .OUT_REG(1'b1)) u_dut (
        .in_clk(clk), .out_clk(clk), .clr_n(clr_n), .in_ce(in_ce), .out_ce(out_ce),
        .addr_hold_n(hold_n), .addr(addr), .wdata(wdata), .wr_en(we),
        .byte_en(be), .rd_en(re), .rdata(rd_main));

    spram_wrap #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW), .OUT_REG(1'b0)) u_dut_flow (
        .in_clk(clk), .out_clk(clk), .clr_n(clr_n), .in_ce(in_ce), .out_ce(out_ce),
        .addr_hold_n(hold_n), .addr(addr), .wdata(wdata), .wr_en(we),
        .byte_en(be), .rd_en(re), .rdata(rd_flow));

    spram_wrap #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW), .OUT_REG(1'b1),
                 .DUAL_CLK(1'b1)) u_dut_dual (
        .in_clk(clk), .out_clk(oclk), .clr_n(clr_n), .in_ce(in_ce), .out_ce(1'b1),
        .addr_hold_n(hold_n), .addr(addr), .wdata(wdata), .wr_en(we),
        .byte_en(be), .rd_en(re), .rdata(rd_dual));

    logic [DW-1:0] mmem [DEPTH];
    logic [AW-1:0] m_ahold;
    logic [DW-1:0] m_q1, m_q2;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Word that a masked write leaves behind.
    function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                            input logic [NB-1:0] m);
        logic [DW-1:0] r;
        for (int l = 0; l < NB; l++) r[l*BW +: BW] = m[l] ? n[l*BW +: BW] : o[l*BW +: BW];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 16'h1357) ^ 16'hA5C3);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One input-clock cycle: drive, update the model at the edge, compare after.
    task automatic step(input string tag, input int a, input logic [DW-1:0] d,
                        input bit w, input logic [NB-1:0] m, input bit r,
                        input bit hn, input bit ice, input bit oce);
        logic [AW-1:0] eff;
        logic [DW-1:0] nw;
        addr = AW'(a); wdata = d; we = w; be = m; re = r;
        hold_n = hn; in_ce = ice; out_ce = oce;
        @(posedge clk);
        if (oce) m_q2 = m_q1;
        if (ice) begin
            eff = hn ? AW'(a) : m_ahold;
            m_ahold = eff;
            nw = merge(mmem[eff], d, m);
            if (r) m_q1 = w ? nw : mmem[eff];
            if (w) mmem[eff] = nw;
        end
        @(negedge clk);
        check(tag, "one-stage port", rd_flow, m_q1);
        check(tag, "two-stage port", rd_main, m_q2);
    endtask

    task automatic do_clear(input string tag);
        clr_n = 1'b0;
        m_ahold = '0; m_q1 = '0; m_q2 = '0;
        #1;
        check(tag, "one-stage cleared", rd_flow, '0);
        check(tag, "two-stage cleared", rd_main, '0);
        check(tag, "dual cleared", rd_dual, '0);
        @(negedge clk);
        clr_n = 1'b1;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
        m_ahold = '0; m_q1 = '0; m_q2 = '0;
        @(negedge clk);
        oclk = 1'b1; #1; oclk = 1'b0;
        @(negedge clk);
        // R9: reset state of every port register.
        check("R9", "reset one-stage", rd_flow, '0);
        check("R9", "reset two-stage", rd_main, '0);
        check("R9", "reset dual", rd_dual, '0);
        clr_n = 1'b1;

        // R1: every word reads zero after start-up.
        for (int a = 0; a < DEPTH; a++) step("R1", a, '0, 0, '1, 1, 1, 1, 1);
        // R2: full-word writes, then reads at both latencies.
        for (int a = 0; a < DEPTH; a++) step("R2", a, pat(a), 1, '1, 0, 1, 1, 1);
        for (int a = 0; a < DEPTH; a++) step("R2", a, '0, 0, '1, 1, 1, 1, 1);
        // R3: each lane mask pattern across all words.
        for (int a = 0; a < DEPTH; a++) step("R3", a, ~pat(a), 1, NB'(a % 4), 0, 1, 1, 1);
        for (int a = 0; a < DEPTH; a++) step("R3", a, '0, 0, '1, 1, 1, 1, 1);
        // R4: read-during-write under each mask.
        for (int a = 0; a < 8; a++)
            step("R4", a, DW'(a * 16'h0F0F + 1), 1, NB'(a % 4), 1, 1, 1, 1);
        step("R4", 0, '0, 0, '1, 1, 1, 1, 1);
        // R5: held address redirects both write and read.
        step("R5", 3, '0, 0, '1, 1, 1, 1, 1);
        step("R5", 9, 16'hBEEF, 1, '1, 1, 0, 1, 1);
        step("R5", 12, '0, 0, '1, 1, 0, 1, 1);
        step("R5", 9, '0, 0, '1, 1, 1, 1, 1);
        step("R5", 3, '0, 0, '1, 1, 1, 1, 1);
        // R6: read strobe low keeps the read result.
        step("R6", 5, '0, 0, '1, 1, 1, 1, 1);
        step("R6", 6, '0, 0, '1, 0, 1, 1, 1);
        step("R6", 6, 16'h6666, 1, '1, 0, 1, 1, 1);
        step("R6", 6, '0, 0, '1, 1, 1, 1, 1);
        // R7: input enable low blocks the write and the read.
        step("R7", 7, 16'h1234, 1, '1, 1, 1, 0, 1);
        step("R7", 7, 16'h1234, 1, '1, 1, 0, 0, 1);
        step("R7", 7, '0, 0, '1, 1, 1, 1, 1);
        // R8: output enable low holds the two-stage port.
        step("R8", 2, '0, 0, '1, 1, 1, 1, 0);
        step("R8", 4, '0, 0, '1, 1, 1, 1, 0);
        step("R8", 4, '0, 0, '1, 1, 1, 1, 1);
        // R9: clear mid-run, then stored words survive.
        do_clear("R9");
        step("R9", 0, '0, 0, '1, 1, 0, 1, 1);
        step("R9", 3, '0, 0, '1, 1, 1, 1, 1);
        step("R9", 6, '0, 0, '1, 1, 1, 1, 1);
        // R10: dual-clock port moves only on output-clock edges.
        step("R10", 9, '0, 0, '1, 1, 1, 1, 1);
        check("R10", "dual before output edge", rd_dual, '0);
        oclk = 1'b1; #1; oclk = 1'b0; #1;
        check("R10", "dual after output edge", rd_dual, m_q1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule